// File: doc/BRIEF.md
# Time-Code Host Register Port

This block is the host-side register front end of a time-code engine. A host bus reaches four byte-wide direct registers through a select line and a two-bit register index. The first direct register gathers four interrupt flags and their enables. The second returns a live status byte. The third holds a pointer into a 64-byte indirect space. The fourth is the data window onto the location that pointer names.

The indirect space is split into three regions. The lowest eight locations show the most recently received 64-bit frame and cannot be written. The next eight hold the frame waiting to be transmitted, and they drive a parallel output. The remaining locations are plain read/write storage. An auto-increment mode lets the host move through sequential locations without reloading the pointer. A single interrupt line goes high while any flag is set and enabled.

Top module: `tcode_host_port`

## Requirements
- R1: After synchronous reset, every enable, every flag, the pointer, the auto-increment bit and all writable indirect locations are 0, and `irq` is low.
- R2: A read of register 0 returns the enables in bits 7:4 and the flags in bits 3:0. A write to register 0 loads the enables from bits 7:4 and leaves the flags unchanged. The flag order from bit 0 upward is frame received, frame transmitted, video line, timer.
- R3: A 1 on `evt_in[i]` at a clock edge sets flag i, and the flag stays set until register 0 is read.
- R4: A read of register 0 clears all flags at the end of that access. A flag whose event arrives at the same edge stays set.
- R5: `irq` is high exactly when some flag and its matching enable are both 1.
- R6: Register 1 reads as `status_in`. Writes to register 1 change nothing.
- R7: Register 2 reads as {auto-increment bit 7, 0 in bit 6, pointer in bits 5:0}. A write loads bit 7 and bits 5:0 and ignores bit 6.
- R8: Register 3 accesses the location the pointer names. Location k in 0..7 reads as `rx_frame[8k+7:8k]`.
- R9: Locations 8..15 are writable, and location 8+k drives `tx_frame[8k+7:8k]`.
- R10: Writes to locations 0..7 are ignored.
- R11: With auto-increment set, each read or write of register 3 advances the pointer by one, and the pointer wraps from 63 to 0.
- R12: With auto-increment clear, accesses to register 3 leave the pointer unchanged.
- R13: With `bus_cs` low, reads and writes have no effect, and `bus_rdata` is 0.
- R14: Locations 16..63 keep whatever was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Select for the register group |
| bus_addr | input | 2 | Direct register index |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; combinational, 0 unless selected and reading |
| evt_in | input | 4 | Single-cycle interrupt events |
| status_in | input | 8 | Live status byte shown in register 1 |
| rx_frame | input | 64 | Received frame shown at locations 0..7 |
| tx_frame | output | 64 | Frame held at locations 8..15 |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted pointer shows up on the very next data-window read, because the returned byte comes from the wrong location. The same error also appears at once in the next read of register 2. A flag that was lost or stuck is visible on `irq` in the cycle after the edge where it went wrong, provided it is enabled. Otherwise it is visible in the next read of register 0. A stray write into the transmit region changes `tx_frame` one cycle later. The bench compares `irq` and `tx_frame` with its model on every cycle, so such faults are caught within a single clock.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    localparam int DATA_W   = 8;
    localparam int SPACE    = 64;
    localparam int PTR_W    = $clog2(SPACE);
    localparam int RO_LOCS  = 8;
    localparam int TX_LOCS  = 8;
    localparam int NUM_IRQ  = 4;
    localparam int FRAME_W  = RO_LOCS * DATA_W;

    typedef enum logic [1:0] {
        REG_IRQ  = 2'd0,
        REG_STAT = 2'd1,
        REG_PTR  = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
        return p + PTR_W'(1);
    endfunction
endpackage

// File: rtl/tcp_irq_ctl.sv
module tcp_irq_ctl
    import tcp_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_clr,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables,
    output logic         irq
);
    logic [N-1:0] flags_q, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            en_q    <= '0;
        end else begin
            flags_q <= (rd_clr ? '0 : flags_q) | evt;
            if (en_wr) en_q <= en_wdata;
        end
    end

    assign flags   = flags_q;
    assign enables = en_q;
    assign irq     = |(flags_q & en_q);

    // R3: an event always lands in its flag
    a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
    // R4: a read with no coincident event leaves no flag set
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/tcp_ptr.sv
module tcp_ptr
    import tcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              step,
    output logic [PTR_W-1:0]  ptr,
    output logic              autoinc
);
    logic [PTR_W-1:0] ptr_q;
    logic             ai_q;
    logic             unused_bit6;

    assign unused_bit6 = load_data[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            ai_q  <= 1'b0;
        end else if (load) begin
            ptr_q <= load_data[PTR_W-1:0];
            ai_q  <= load_data[DATA_W-1];
        end else if (step && ai_q) begin
            ptr_q <= ptr_advance(ptr_q);
        end
    end

    assign ptr     = ptr_q;
    assign autoinc = ai_q;

    // R11: stepping advances by one with wrap
    a_r11_step_advances: assert property (@(posedge clk) disable iff (rst)
        (step && autoinc && !load) |=> (ptr == PTR_W'($past(ptr) + PTR_W'(1))));
    // R12: no load and no auto step keeps the pointer
    a_r12_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        (!load && !(step && autoinc)) |=> $stable(ptr));
endmodule

// File: rtl/tcp_store.sv
module tcp_store
    import tcp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [PTR_W-1:0]   addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [FRAME_W-1:0] rx_frame,
    output logic [DATA_W-1:0]  rdata,
    output logic [FRAME_W-1:0] tx_frame
);
    localparam int RO_W = $clog2(RO_LOCS);
    localparam logic [PTR_W-1:0] RO_LIM = PTR_W'(RO_LOCS);

    logic [DATA_W-1:0] mem_q [RO_LOCS:SPACE-1];
    logic [DATA_W-1:0] rx_b  [RO_LOCS];
    logic              writable;

    assign writable = (addr >= RO_LIM);

    for (genvar gi = 0; gi < RO_LOCS; gi++) begin : g_rx
        assign rx_b[gi] = rx_frame[gi*DATA_W +: DATA_W];
    end

    for (genvar gt = 0; gt < TX_LOCS; gt++) begin : g_tx
        assign tx_frame[gt*DATA_W +: DATA_W] = mem_q[RO_LOCS + gt];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = RO_LOCS; i < SPACE; i++) mem_q[i] <= '0;
        end else if (wr && writable) begin
            mem_q[addr] <= wdata;
        end
    end

    always_comb begin
        if (writable) rdata = mem_q[addr];
        else          rdata = rx_b[addr[RO_W-1:0]];
    end

    // R10: writes into the receive region never move the transmit frame
    a_r10_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && !writable) |=> $stable(tx_frame));
    // R9: a write into the transmit region appears on the frame output
    a_r9_tx_follows_write: assert property (@(posedge clk) disable iff (rst)
        (wr && writable && addr < PTR_W'(RO_LOCS + TX_LOCS)) |=>
        (tx_frame[($past(addr) - RO_LIM) * DATA_W +: DATA_W] == $past(wdata)));
endmodule

// File: rtl/tcode_host_port.sv
module tcode_host_port
    import tcp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_cs,
    input  logic [1:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_IRQ-1:0] evt_in,
    input  logic [DATA_W-1:0]  status_in,
    input  logic [FRAME_W-1:0] rx_frame,
    output logic [FRAME_W-1:0] tx_frame,
    output logic               irq
);
    bus_op_t            op;
    logic [NUM_IRQ-1:0] flags, enables;
    logic [PTR_W-1:0]   ptr;
    logic               autoinc;
    logic [DATA_W-1:0]  win_data;
    logic               rd_clr, en_wr, ptr_load, win_step, win_wr;

    assign op.rd  = bus_cs && bus_rd;
    assign op.wr  = bus_cs && bus_wr;
    assign op.sel = reg_sel_e'(bus_addr);

    assign rd_clr   = op.rd && op.sel == REG_IRQ;
    assign en_wr    = op.wr && op.sel == REG_IRQ;
    assign ptr_load = op.wr && op.sel == REG_PTR;
    assign win_wr   = op.wr && op.sel == REG_DATA;
    assign win_step = (op.rd || op.wr) && op.sel == REG_DATA;

    tcp_irq_ctl #(.N(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .rd_clr   (rd_clr),
        .en_wr    (en_wr),
        .en_wdata (bus_wdata[DATA_W-1 -: NUM_IRQ]),
        .evt      (evt_in),
        .flags    (flags),
        .enables  (enables),
        .irq      (irq)
    );

    tcp_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_data (bus_wdata),
        .step      (win_step),
        .ptr       (ptr),
        .autoinc   (autoinc)
    );

    tcp_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (win_wr),
        .addr     (ptr),
        .wdata    (bus_wdata),
        .rx_frame (rx_frame),
        .rdata    (win_data),
        .tx_frame (tx_frame)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.rd) begin
            unique case (op.sel)
                REG_IRQ:  bus_rdata = {enables, flags};
                REG_STAT: bus_rdata = status_in;
                REG_PTR:  bus_rdata = {autoinc, 1'b0, ptr};
                REG_DATA: bus_rdata = win_data;
            endcase
        end
    end

    // R5: clearing every enable silences the interrupt on the next cycle
    a_r5_masked_no_irq: assert property (@(posedge clk) disable iff (rst)
        (en_wr && bus_wdata[DATA_W-1 -: NUM_IRQ] == '0) |=> !irq);
    // R13: an unselected bus drives no read data
    a_r13_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !bus_cs |-> (bus_rdata == '0));
endmodule

// File: tb/test_tcode_host_port.sv
module test_tcode_host_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0, rdata, stat = 8'h5A;
    logic [3:0]  evt = '0;
    logic [63:0] rxf = 64'h8877_6655_4433_2211, txf;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [3:0] m_fl = '0, m_en = '0;
    int         m_ptr = 0;
    bit         m_ai = 0;
    logic [7:0] m_mem [64];

    always #4 clk = ~clk;

    tcode_host_port i_tcode_host_port (
        .clk(clk), .rst(rst), .bus_cs(cs), .bus_addr(addr), .bus_rd(rd),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .evt_in(evt),
        .status_in(stat), .rx_frame(rxf), .tx_frame(txf), .irq(irq)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {m_en, m_fl};
            2'd1: return stat;
            2'd2: return {m_ai, 1'b0, 6'(m_ptr)};
            default: return (m_ptr < 8) ? rxf[m_ptr*8 +: 8] : m_mem[m_ptr];
        endcase
    endfunction

    function automatic logic [63:0] m_tx();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_mem[8+k];
        return v;
    endfunction

    task automatic cyc(input bit c, input logic [1:0] a, input bit r, input bit w,
                       input logic [7:0] d, input logic [3:0] ev, input string tag);
        @(negedge clk);
        check(64'(irq), 64'(|(m_fl & m_en)), "R5 irq");
        check(txf, m_tx(), "R9 tx_frame");
        cs = c; addr = a; rd = r; wr = w; wdata = d; evt = ev;
        #1;
        if (r) check(64'(rdata), c ? 64'(m_read(a)) : 64'd0, tag);
        @(posedge clk);
        if (c && r && a == 2'd0) m_fl = ev;
        else                     m_fl = m_fl | ev;
        if (c && w && a == 2'd0) m_en = d[7:4];
        if (c && w && a == 2'd2) begin m_ai = d[7]; m_ptr = d[5:0]; end
        if (c && (r || w) && a == 2'd3) begin
            if (w && m_ptr >= 8) m_mem[m_ptr] = d;
            if (m_ai) m_ptr = (m_ptr + 1) % 64;
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, input string tag);
        cyc(1, a, 1, 0, 8'h00, 4'h0, tag);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(1, a, 0, 1, d, 4'h0, tag);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        rd_reg(2'd0, "R1 reg0 after reset");
        rd_reg(2'd2, "R1 reg2 after reset");
        rd_reg(2'd1, "R6 status read");
        check(64'(irq), 64'd0, "R1 irq after reset");
        // R2 enables write, flags unchanged
        wr_reg(2'd0, 8'hFF, "R2 write enables");
        rd_reg(2'd0, "R2 enables readback");
        // R3 event then read clears (R4)
        cyc(0, 2'd0, 0, 0, 8'h00, 4'b0001, "R3 event");
        cyc(0, 2'd0, 0, 0, 8'h00, 4'b0000, "R3 idle");
        rd_reg(2'd0, "R3 flag held");
        rd_reg(2'd0, "R4 flags cleared");
        // R4 coincident event kept
        cyc(0, 2'd0, 0, 0, 8'h00, 4'b0010, "R4 pre event");
        cyc(1, 2'd0, 1, 0, 8'h00, 4'b0100, "R4 read with event");
        rd_reg(2'd0, "R4 coincident kept");
        // R5 masking
        wr_reg(2'd0, 8'h00, "R5 disable all");
        cyc(0, 2'd0, 0, 0, 8'h00, 4'b1000, "R5 masked event");
        wr_reg(2'd0, 8'h80, "R5 enable timer");
        rd_reg(2'd0, "R5 timer flag");
        // R6 status ignores writes
        wr_reg(2'd1, 8'hFF, "R6 write status");
        stat = 8'hC3;
        rd_reg(2'd1, "R6 status after write");
        rd_reg(2'd0, "R6 reg0 untouched");
        // R7 bit6 reads 0
        wr_reg(2'd2, 8'hFF, "R7 write ptr");
        rd_reg(2'd2, "R7 ptr readback");
        // R8 / R11 walk receive region
        wr_reg(2'd2, 8'h80, "R11 load ptr 0 ai");
        for (int k = 0; k < 8; k++) rd_reg(2'd3, "R8 rx byte");
        rd_reg(2'd2, "R11 ptr after reads");
        // R9 fill transmit region
        for (int k = 0; k < 8; k++) wr_reg(2'd3, 8'hA0 + 8'(k), "R9 tx write");
        wr_reg(2'd2, 8'h88, "R9 ptr 8");
        for (int k = 0; k < 8; k++) rd_reg(2'd3, "R9 tx readback");
        // R10 / R12
        wr_reg(2'd2, 8'h02, "R12 ptr 2 no ai");
        wr_reg(2'd3, 8'h77, "R10 write ro loc");
        rd_reg(2'd3, "R10 ro loc unchanged");
        rd_reg(2'd2, "R12 ptr held");
        // R11 wrap, R14 storage
        wr_reg(2'd2, 8'hBE, "R11 ptr 62 ai");
        wr_reg(2'd3, 8'h3C, "R14 write 62");
        wr_reg(2'd3, 8'hC5, "R14 write 63");
        rd_reg(2'd2, "R11 wrap to 0");
        wr_reg(2'd2, 8'h3E, "R14 ptr 62");
        rd_reg(2'd3, "R14 read 62");
        wr_reg(2'd2, 8'h3F, "R14 ptr 63");
        rd_reg(2'd3, "R14 read 63");
        wr_reg(2'd2, 8'h14, "R14 ptr 20");
        rd_reg(2'd3, "R14 untouched loc");
        // R13 unselected access
        cyc(0, 2'd2, 0, 1, 8'h85, 4'h0, "R13 idle write");
        cyc(0, 2'd0, 1, 0, 8'h00, 4'h0, "R13 idle rdata");
        rd_reg(2'd2, "R13 ptr unchanged");
        rd_reg(2'd0, "R13 flags unchanged");
        cyc(0, 2'd0, 0, 0, 8'h00, 4'h0, "idle");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule